// File: doc/BRIEF.md
# Flag-Setting Add/Subtract Unit

This block is a 32-bit arithmetic slice that performs addition and subtraction, each with and without a carry input. Every operation also produces four condition flags: negative, zero, carry and overflow. The carry input for the carry-consuming operations comes from the unit's own stored carry flag. Multi-word arithmetic therefore chains naturally: one operation runs after another, and each one sees the carry that the previous flag-updating operation left behind.

The result is combinational from the operands, the opcode and the stored carry. The four flags are held in a register. That register loads the freshly computed flags on a rising clock edge only while the flag-write input is high. On subtraction the carry flag means "no borrow". The opcode is 2 bits wide: 00 add, 01 add-with-carry, 10 subtract, 11 subtract-with-carry.

Top module: `arith_flag_unit`

## Requirements
- R1: With opcode 00 the result is (a + b) mod 2^32, and the carry computed for it is 1 exactly when that result is below a, compared as unsigned.
- R2: With opcode 01 and the stored carry at 1, the result is a + b + 1 and the carry is 1 when the result is at or below a, unsigned. With the stored carry at 0, it behaves like opcode 00.
- R3: With opcode 10 the result is a - b, and the carry is 1 exactly when a >= b, unsigned (no borrow).
- R4: With opcode 11 and the stored carry at 0, the result is a - b - 1 and the carry is a > b. With the stored carry at 1, the result is a - b and the carry is a >= b.
- R5: The overflow flag is 1 exactly when the true signed two's-complement value of the operation falls outside the 32-bit signed range.
- R6: The negative flag equals bit 31 of the result, and the zero flag is 1 exactly when the result is all zeros.
- R7: The four flags take the computed values on a rising edge where flag_we is 1. On an edge where it is 0 they keep their values, whatever the opcode and operands.
- R8: A rising edge with rst high clears all four flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| op | input | 2 | Operation: 00 add, 01 add-with-carry, 10 subtract, 11 subtract-with-carry |
| flag_we | input | 1 | Load the flag register at this edge |
| result | output | 32 | Combinational result |
| flag_n | output | 1 | Stored negative flag |
| flag_z | output | 1 | Stored zero flag |
| flag_c | output | 1 | Stored carry / no-borrow flag |
| flag_v | output | 1 | Stored overflow flag |

## Verification
The assertions assume that opa, opb and op stay steady through each clock period, so that the value of result sampled at an edge is the value whose flags get stored. The bench meets this by changing inputs only at falling edges. The carry-rule assertions also rely on the stored carry being the one the current result was computed from. This holds because each operation is launched at most once between edges. The stimulus walks a table of boundary operands (all-ones, sign-bit limits, equal operands) in chains where carries feed carry-consuming operations, then issues random operations with random flag-write enables.

// File: rtl/afu_pkg.sv
package afu_pkg;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_ADC = 2'b01,
        OP_SUB = 2'b10,
        OP_SBC = 2'b11
    } afu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } afu_flags_t;

    function automatic logic op_is_sub(input afu_op_e o);
        return o[1];
    endfunction

    function automatic logic op_takes_carry(input afu_op_e o);
        return o[0];
    endfunction
endpackage

// File: rtl/afu_operand_prep.sv
module afu_operand_prep
    import afu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  afu_op_e        op,
    input  logic [W-1:0]   b_in,
    input  logic           stored_c,
    output logic [W-1:0]   b_eff,
    output logic           cin
);
    // Subtraction adds the inverted operand; the implicit +1 comes from cin.
    always_comb begin
        b_eff = op_is_sub(op) ? ~b_in : b_in;
        if (op_takes_carry(op))
            cin = stored_c;
        else
            cin = op_is_sub(op);
    end
endmodule

// File: rtl/afu_adder.sv
module afu_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W:0] wide;

    always_comb begin
        wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        sum  = wide[W-1:0];
        cout = wide[W];
        // Signed overflow: operands agree in sign, sum differs from them.
        ovf  = ~(a[W-1] ^ b[W-1]) & (a[W-1] ^ wide[W-1]);
    end
endmodule

// File: rtl/afu_flag_reg.sv
module afu_flag_reg
    import afu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  afu_flags_t d,
    output afu_flags_t q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (we)
            q <= d;
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !we |=> q == $past(q)); // R7

    AST_LOAD_ON_WE: assert property (@(posedge clk) disable iff (rst)
        we |=> q == $past(d)); // R7
endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
    import afu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic [1:0]   op,
    input  logic         flag_we,
    output logic [W-1:0] result,
    output logic         flag_n,
    output logic         flag_z,
    output logic         flag_c,
    output logic         flag_v
);
    afu_op_e      op_q;
    logic [W-1:0] b_eff;
    logic         cin;
    logic         cout;
    logic         ovf;
    afu_flags_t   next_flags;
    afu_flags_t   cur_flags;

    assign op_q = afu_op_e'(op);

    afu_operand_prep #(.W(W)) u_prep (
        .op       (op_q),
        .b_in     (opb),
        .stored_c (cur_flags.c),
        .b_eff    (b_eff),
        .cin      (cin)
    );

    afu_adder #(.W(W)) u_add (
        .a    (opa),
        .b    (b_eff),
        .cin  (cin),
        .sum  (result),
        .cout (cout),
        .ovf  (ovf)
    );

    always_comb begin
        next_flags.n = result[W-1];
        next_flags.z = (result == '0);
        next_flags.c = cout;
        next_flags.v = ovf;
    end

    afu_flag_reg u_flags (
        .clk (clk),
        .rst (rst),
        .we  (flag_we),
        .d   (next_flags),
        .q   (cur_flags)
    );

    assign flag_n = cur_flags.n;
    assign flag_z = cur_flags.z;
    assign flag_c = cur_flags.c;
    assign flag_v = cur_flags.v;

    AST_ADD_CARRY: assert property (@(posedge clk) disable iff (rst)
        (flag_we && op == OP_ADD) |=> flag_c == ($past(result) < $past(opa))); // R1

    AST_ADC_CARRY_SET: assert property (@(posedge clk) disable iff (rst)
        (flag_we && op == OP_ADC && flag_c) |=> flag_c == ($past(result) <= $past(opa))); // R2

    AST_SUB_CARRY: assert property (@(posedge clk) disable iff (rst)
        (flag_we && op == OP_SUB) |=> flag_c == ($past(opa) >= $past(opb))); // R3

    AST_SBC_CARRY_CLR: assert property (@(posedge clk) disable iff (rst)
        (flag_we && op == OP_SBC && !flag_c) |=> flag_c == ($past(opa) > $past(opb))); // R4

    AST_NEG_ZERO: assert property (@(posedge clk) disable iff (rst)
        flag_we |=> (flag_n == $past(result[W-1])) && (flag_z == ($past(result) == '0))); // R6
endmodule

// File: tb/arith_flag_unit_test.sv
module arith_flag_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] opa, opb;
    logic [1:0]  op;
    logic        flag_we;
    logic [31:0] result;
    logic        flag_n, flag_z, flag_c, flag_v;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    logic m_n, m_z, m_c, m_v;

    always #2 clk = ~clk;

    arith_flag_unit uut (
        .clk(clk), .rst(rst), .opa(opa), .opb(opb), .op(op),
        .flag_we(flag_we), .result(result),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
    );

    // {op, a, b}
    localparam int NV = 16;
    localparam logic [65:0] VEC [NV] = '{
        {2'b00, 32'hFFFF_FFFF, 32'h0000_0001},
        {2'b01, 32'hFFFF_FFFF, 32'h0000_0000},
        {2'b01, 32'h0000_0005, 32'h0000_0007},
        {2'b00, 32'h7FFF_FFFF, 32'h0000_0001},
        {2'b00, 32'h8000_0000, 32'h8000_0000},
        {2'b10, 32'h0000_0000, 32'h0000_0001},
        {2'b11, 32'h0000_0005, 32'h0000_0005},
        {2'b11, 32'h0000_0003, 32'h0000_0003},
        {2'b10, 32'h0000_0005, 32'h0000_0005},
        {2'b11, 32'h0000_0009, 32'h0000_0002},
        {2'b10, 32'h8000_0000, 32'h0000_0001},
        {2'b10, 32'h7FFF_FFFF, 32'hFFFF_FFFF},
        {2'b01, 32'h7FFF_FFFF, 32'h0000_0000},
        {2'b00, 32'h0000_0000, 32'h0000_0000},
        {2'b11, 32'h0000_0000, 32'h0000_0000},
        {2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference built from the stated per-operation rules and exact signed arithmetic.
    task automatic model(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                         output logic [31:0] r, output logic c, output logic v);
        longint sa, sb, ex;
        logic ci;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        ci = m_c;
        case (o)
            2'b00: begin r = a + b; c = (r < a); ex = sa + sb; end
            2'b01: begin
                r = a + b + {31'd0, ci};
                c = ci ? (r <= a) : (r < a);
                ex = sa + sb + longint'(ci);
            end
            2'b10: begin r = a - b; c = (a >= b); ex = sa - sb; end
            default: begin
                r = a - b - {31'd0, ~ci};
                c = ci ? (a >= b) : (a > b);
                ex = sa - sb - longint'(~ci);
            end
        endcase
        v = (ex > 64'sd2147483647) || (ex < -64'sd2147483648);
    endtask

    task automatic run_op(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                          input logic we, input string req);
        logic [31:0] er;
        logic ec, ev;
        @(negedge clk);
        op = o; opa = a; opb = b; flag_we = we;
        model(o, a, b, er, ec, ev);
        #1;
        chk({req, " result"}, result, er);
        @(posedge clk); #1;
        if (we) begin
            m_n = er[31]; m_z = (er == 32'd0); m_c = ec; m_v = ev;
        end
        chk({req, " R6 N"}, {31'd0, flag_n}, {31'd0, m_n});
        chk({req, " R6 Z"}, {31'd0, flag_z}, {31'd0, m_z});
        chk({req, " carry"}, {31'd0, flag_c}, {31'd0, m_c});
        chk({req, " R5 V"}, {31'd0, flag_v}, {31'd0, m_v});
    endtask

    function automatic string req_of(input logic [1:0] o);
        case (o)
            2'b00: return "R1";
            2'b01: return "R2";
            2'b10: return "R3";
            default: return "R4";
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; opa = '0; opb = '0; op = 2'b00; flag_we = 1'b0;
        m_n = 0; m_z = 0; m_c = 0; m_v = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R8 reset flags", {28'd0, flag_n, flag_z, flag_c, flag_v}, 32'd0);
        @(negedge clk); rst = 1'b0;

        for (int i = 0; i < NV; i++)
            run_op(VEC[i][65:64], VEC[i][63:32], VEC[i][31:0], 1'b1, req_of(VEC[i][65:64]));

        // R7: set carry, then a carry-producing op with we low must leave flags intact
        run_op(2'b00, 32'hFFFF_FFFF, 32'h1, 1'b1, "R1 setup");
        run_op(2'b10, 32'h0, 32'h1, 1'b0, "R7 hold");
        run_op(2'b00, 32'h7FFF_FFFF, 32'h1, 1'b0, "R7 hold");
        // stored carry still 1, seen by add-with-carry
        run_op(2'b01, 32'h1, 32'h1, 1'b1, "R2 R7 carry kept");

        // R8: reset after flags are set
        run_op(2'b10, 32'h0, 32'h1, 1'b1, "R3 pre-reset");
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        chk("R8 reset clears", {28'd0, flag_n, flag_z, flag_c, flag_v}, 32'd0);
        m_n = 0; m_z = 0; m_c = 0; m_v = 0;
        @(negedge clk); rst = 1'b0;

        for (int i = 0; i < 400; i++) begin
            logic [1:0] o;
            logic [31:0] a, b;
            o = 2'($urandom);
            a = $urandom;
            b = (i % 8 == 0) ? a : $urandom;
            run_op(o, a, b, ($urandom % 4) != 0, req_of(o));
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule